// File: doc/BRIEF.md
# Interval Up-Counter with Two Match Outputs

This block is a 16-bit up-counter whose period is set by a compare register. Software programs it over a small register bus that carries byte or halfword accesses. When counting is switched on, the counter latches compare register A as its period, restarts from zero and advances by one on each peripheral tick. On the tick that would make the count equal to the period, it wraps to zero and raises a one-cycle overflow pulse.

Two match outputs give extra timing points inside the period. Each output has its own compare value and its own enable byte, and it pulses when a tick moves the counter onto that value. Writes that set reserved mode bits, or that use an access size the target register does not support, are rejected: the register keeps its old value and the bus response carries an error flag.

The control path is a three-state machine. ST_STOP means counting is off and the count is held at zero. ST_RUN means counting is on with a nonzero period. ST_HOLD means counting is on but the latched period is zero, so the counter stays idle. Every transition is caused by an accepted write to the run-control byte, and each such write restarts the count at zero. The transitions are:
- STOP to RUN or HOLD: enable written with compare A nonzero or zero.
- RUN to STOP and HOLD to STOP: enable cleared.
- RUN or HOLD to RUN or HOLD: enable written again, which re-latches the period.

Top module: `ucmp_timer`

Register map, by byte address:

| Address | Register | Access |
|---|---|---|
| 0 | Mode byte 0 | byte; halfword also allowed here, covering both mode bytes |
| 1 | Run-control byte | byte |
| 2 | Match-A enable | byte |
| 3 | Match-B enable | byte |
| 4 | Compare A, low byte | byte; halfword also allowed here, covering all of compare A |
| 5 | Compare A, high byte | byte |
| 6 | Compare B, low byte | byte; halfword also allowed here, covering all of compare B |
| 7 | Compare B, high byte | byte |
| 8 | Counter, low byte | read only; byte or halfword |
| 9 | Counter, high byte | read only; byte |

## Requirements
- R1: After reset, every register reads zero, the counter reads zero, and ovf_o, match_a_o, match_b_o, bus_ack and bus_err are low.
- R2: An accepted write to the run-control byte does three things. If bit 7 of that byte is 1, it latches compare A as the period. It clears the count to zero. It then sets the state: stopped if bit 7 is 0, otherwise running. A running counter advances by one on each clock edge where cnt_tick is high. The run-control byte is written either by a byte write at address 1 or by a halfword write at address 0.
- R3: A tick taken while the count equals the period minus one wraps the count to 0 and drives ovf_o high for exactly the following cycle. A period of 1 therefore gives an overflow on every tick.
- R4: Enabling while compare A is zero leaves the count at zero, with no overflow or match pulses.
- R5: Writing bit 7 of the run-control byte as 0 stops counting at once, clears the count, and ends all pulses. Writing compare A while the counter runs does not change the period until the next enable write.
- R6: match_a_o (match_b_o) pulses for one cycle after a counting tick whose pre-wrap count+1 equals compare A (compare B). This happens only while bit 0 of the match-A (match-B) enable byte is 1.
- R7: A write to mode byte 0 that sets any of bits 5, 3 or 2 is rejected with bus_err, and the register keeps its old value.
- R8: A write to the run-control byte is rejected with bus_err, and changes nothing, if it sets any of bits 2:0, or sets bit 7 (enable) and bit 6 (load) together.
- R9: Some accesses give bus_err and change nothing: halfword accesses at any odd address or at addresses 2 and 3, any write to addresses 8 or 9, and any access to addresses 10 to 15. A halfword write at 0 takes byte 0 from bus_wdata[15:8] and the run-control byte from [7:0]; it is rejected as a whole if either byte is illegal.
- R10: Every request is answered by bus_ack in the following cycle. Byte reads return the byte zero-extended in bus_rdata[7:0]. A halfword read at address 0 returns {byte 0, run-control byte}. Counter reads return the count held before the request edge. Write responses and error responses carry zero data.
- R11: A byte write to address 0 alone does not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Peripheral tick; one count step per high cycle |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hw | input | 1 | 1 = halfword, 0 = byte |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data; byte writes use [7:0] |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Response strobe, one cycle after request |
| bus_err | output | 1 | Access rejected, valid with bus_ack |
| ovf_o | output | 1 | Period overflow pulse |
| match_a_o | output | 1 | Compare-A match pulse |
| match_b_o | output | 1 | Compare-B match pulse |

## Verification
The bench builds the block with its default parameters: a 4-bit address and a 16-bit count. That address width makes the unmapped addresses 10 to 15 reachable, so rejected decodes can be tested. Small compare values (1, 3, 5, 9) bring wrap, back-to-back overflow and coinciding match pulses within a few cycles. Full halfword writes exercise both byte lanes of each compare register. Ticks are driven continuously, every third cycle, and not at all, so the tests cover both the tick-driven advance and the write-over-tick priority.

// File: rtl/ucmp_pkg.sv
package ucmp_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    localparam int A_MODE0 = 0;
    localparam int A_RUN   = 1;
    localparam int A_MENA  = 2;
    localparam int A_MENB  = 3;
    localparam int A_CA_L  = 4;
    localparam int A_CA_H  = 5;
    localparam int A_CB_L  = 6;
    localparam int A_CB_H  = 7;
    localparam int A_CNT_L = 8;
    localparam int A_CNT_H = 9;

    localparam logic [BYTE_W-1:0] MODE0_RSVD = 8'h2C;
    localparam logic [BYTE_W-1:0] RUN_RSVD   = 8'h07;
    localparam int RUN_EN_BIT   = 7;
    localparam int RUN_LOAD_BIT = 6;

    function automatic logic mode0_ok(input logic [BYTE_W-1:0] v);
        return (v & MODE0_RSVD) == '0;
    endfunction

    function automatic logic run_ok(input logic [BYTE_W-1:0] v);
        return ((v & RUN_RSVD) == '0) && !(v[RUN_EN_BIT] && v[RUN_LOAD_BIT]);
    endfunction
endpackage

// File: rtl/ucmp_regs.sv
module ucmp_regs
    import ucmp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_hw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [15:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic              men_a,
    output logic              men_b,
    output logic              ctl_stb,
    output logic              ctl_en
);
    logic [BYTE_W-1:0] mode0_q, run_q, mena_q, menb_q;
    logic [CNT_W-1:0]  ca_q, cb_q;
    logic              legal;
    logic              wr_ok;
    logic [15:0]       rd_mux;
    logic [15:0]       rdata_q;
    logic              ack_q, err_q;

    // access legality per address and size
    always_comb begin
        legal = 1'b0;
        case (bus_addr)
            ADDR_W'(A_MODE0): begin
                if (!bus_we)
                    legal = 1'b1;
                else if (bus_hw)
                    legal = mode0_ok(bus_wdata[15:8]) && run_ok(bus_wdata[7:0]);
                else
                    legal = mode0_ok(bus_wdata[7:0]);
            end
            ADDR_W'(A_RUN):   legal = !bus_hw && (!bus_we || run_ok(bus_wdata[7:0]));
            ADDR_W'(A_MENA),
            ADDR_W'(A_MENB):  legal = !bus_hw;
            ADDR_W'(A_CA_L),
            ADDR_W'(A_CB_L):  legal = 1'b1;
            ADDR_W'(A_CA_H),
            ADDR_W'(A_CB_H):  legal = !bus_hw;
            ADDR_W'(A_CNT_L): legal = !bus_we;
            ADDR_W'(A_CNT_H): legal = !bus_we && !bus_hw;
            default:          legal = 1'b0;
        endcase
    end

    // read data selection
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(A_MODE0): rd_mux = bus_hw ? {mode0_q, run_q} : {8'h00, mode0_q};
            ADDR_W'(A_RUN):   rd_mux = {8'h00, run_q};
            ADDR_W'(A_MENA):  rd_mux = {8'h00, mena_q};
            ADDR_W'(A_MENB):  rd_mux = {8'h00, menb_q};
            ADDR_W'(A_CA_L):  rd_mux = bus_hw ? ca_q : {8'h00, ca_q[7:0]};
            ADDR_W'(A_CA_H):  rd_mux = {8'h00, ca_q[15:8]};
            ADDR_W'(A_CB_L):  rd_mux = bus_hw ? cb_q : {8'h00, cb_q[7:0]};
            ADDR_W'(A_CB_H):  rd_mux = {8'h00, cb_q[15:8]};
            ADDR_W'(A_CNT_L): rd_mux = bus_hw ? cnt_val : {8'h00, cnt_val[7:0]};
            ADDR_W'(A_CNT_H): rd_mux = {8'h00, cnt_val[15:8]};
            default:          rd_mux = '0;
        endcase
    end

    assign wr_ok   = bus_req && bus_we && legal;
    assign ctl_stb = wr_ok && ((bus_addr == ADDR_W'(A_RUN)) ||
                               (bus_addr == ADDR_W'(A_MODE0) && bus_hw));
    assign ctl_en  = bus_wdata[RUN_EN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode0_q <= '0;
            run_q   <= '0;
            mena_q  <= '0;
            menb_q  <= '0;
            ca_q    <= '0;
            cb_q    <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                ADDR_W'(A_MODE0): begin
                    if (bus_hw) begin
                        mode0_q <= bus_wdata[15:8];
                        run_q   <= bus_wdata[7:0];
                    end else begin
                        mode0_q <= bus_wdata[7:0];
                    end
                end
                ADDR_W'(A_RUN):  run_q  <= bus_wdata[7:0];
                ADDR_W'(A_MENA): mena_q <= bus_wdata[7:0];
                ADDR_W'(A_MENB): menb_q <= bus_wdata[7:0];
                ADDR_W'(A_CA_L): begin
                    if (bus_hw) ca_q <= bus_wdata;
                    else        ca_q[7:0] <= bus_wdata[7:0];
                end
                ADDR_W'(A_CA_H): ca_q[15:8] <= bus_wdata[7:0];
                ADDR_W'(A_CB_L): begin
                    if (bus_hw) cb_q <= bus_wdata;
                    else        cb_q[7:0] <= bus_wdata[7:0];
                end
                ADDR_W'(A_CB_H): cb_q[15:8] <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= bus_req;
            err_q   <= bus_req && !legal;
            rdata_q <= (bus_req && !bus_we && legal) ? rd_mux : '0;
        end
    end

    assign bus_ack   = ack_q;
    assign bus_err   = err_q;
    assign bus_rdata = rdata_q;
    assign cmp_a     = ca_q;
    assign cmp_b     = cb_q;
    assign men_a     = mena_q[0];
    assign men_b     = menb_q[0];

    p_mode0_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_q & MODE0_RSVD) == '0);
    p_run_combo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_q[RUN_EN_BIT] && run_q[RUN_LOAD_BIT]) && ((run_q & RUN_RSVD) == '0));
    p_err_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);
    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req));
    p_err_keeps_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(run_q));
endmodule

// File: rtl/ucmp_ctrl.sv
module ucmp_ctrl
    import ucmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_stb,
    input  logic             ctl_en,
    input  logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cnt_o,
    output logic             adv_o,
    output logic [CNT_W-1:0] raw_o,
    output logic             ovf_o
);
    run_state_t       state_q, state_d, arm_state;
    logic [CNT_W-1:0] cnt_q, per_q, raw;
    logic             adv, wrap, ovf_q;

    assign arm_state = (cmp_a == '0) ? ST_HOLD : ST_RUN;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctl_stb && ctl_en) state_d = arm_state;
            ST_RUN:  if (ctl_stb) state_d = ctl_en ? arm_state : ST_STOP;
            ST_HOLD: if (ctl_stb) state_d = ctl_en ? arm_state : ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    assign adv  = (state_q == ST_RUN) && tick && !ctl_stb;
    assign raw  = cnt_q + 1'b1;
    assign wrap = adv && (cnt_q == per_q - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
            ovf_q <= 1'b0;
        end else if (ctl_stb) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            if (ctl_en) per_q <= cmp_a;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : raw;
            ovf_q <= wrap;
        end else begin
            ovf_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign adv_o = adv;
    assign raw_o = raw;
    assign ovf_o = ovf_q;

    p_stop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (cnt_q == '0));
    p_below_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < per_q));
    p_ovf_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(cnt_q) == per_q - CNT_W'(1)) && (cnt_q == '0));
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !ovf_q);
endmodule

// File: rtl/ucmp_match.sv
module ucmp_match
    import ucmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] raw,
    input  logic [CNT_W-1:0] cmp,
    input  logic             en,
    output logic             hit_o
);
    logic hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= adv && en && (raw == cmp);
    end

    assign hit_o = hit_q;

    p_hit_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(adv) && $past(en));
endmodule

// File: rtl/ucmp_timer.sv
module ucmp_timer
    import ucmp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_hw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic              ovf_o,
    output logic              match_a_o,
    output logic              match_b_o
);
    localparam int N_MATCH = 2;

    logic [CNT_W-1:0] cmp_a, cmp_b, cnt_val, raw;
    logic             men_a, men_b, ctl_stb, ctl_en, adv;
    logic [CNT_W-1:0] cmp_arr [N_MATCH];
    logic             en_arr  [N_MATCH];
    logic             hit_arr [N_MATCH];

    ucmp_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_hw(bus_hw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_val),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .men_a(men_a), .men_b(men_b),
        .ctl_stb(ctl_stb), .ctl_en(ctl_en)
    );

    ucmp_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
        .ctl_stb(ctl_stb), .ctl_en(ctl_en), .cmp_a(cmp_a),
        .cnt_o(cnt_val), .adv_o(adv), .raw_o(raw), .ovf_o(ovf_o)
    );

    assign cmp_arr[0] = cmp_a;
    assign cmp_arr[1] = cmp_b;
    assign en_arr[0]  = men_a;
    assign en_arr[1]  = men_b;

    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
        ucmp_match match_i (
            .clk(clk), .rst_n(rst_n), .adv(adv), .raw(raw),
            .cmp(cmp_arr[g]), .en(en_arr[g]), .hit_o(hit_arr[g])
        );
    end

    assign match_a_o = hit_arr[0];
    assign match_b_o = hit_arr[1];
endmodule

// File: tb/ucmp_timer_tb.sv
module ucmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_hw = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack, bus_err, ovf_o, match_a_o, match_b_o;

    int checks = 0, errors = 0;
    int cyc = 0, tick_pat = 0;
    string phase = "R1";

    // behavioural model state
    int m_b0 = 0, m_run = 0, m_ma = 0, m_mb = 0, m_ca = 0, m_cb = 0;
    int m_cnt = 0, m_per = 0, m_st = 0;
    bit m_ovf = 0, m_ha = 0, m_hb = 0, m_ack = 0, m_err = 0;
    int m_rd = 0;
    int ovf_last = -1, ovf_gap = 0;

    ucmp_timer dut_i (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic bit ok0(int v); return (v & 'h2C) == 0; endfunction
    function automatic bit ok1(int v); return ((v & 7) == 0) && ((v & 'hC0) != 'hC0); endfunction

    function automatic bit legal_f(int a, bit we, bit hw, int wd);
        if (a == 0)  return !we ? 1'b1 : (hw ? (ok0((wd >> 8) & 255) && ok1(wd & 255)) : ok0(wd & 255));
        if (a == 1)  return !hw && (!we || ok1(wd & 255));
        if (a == 2 || a == 3 || a == 5 || a == 7) return !hw;
        if (a == 4 || a == 6) return 1'b1;
        if (a == 8)  return !we;
        if (a == 9)  return !we && !hw;
        return 1'b0;
    endfunction

    function automatic int rd_f(int a, bit hw);
        case (a)
            0: return hw ? (m_b0 * 256 + m_run) : m_b0;
            1: return m_run;
            2: return m_ma;
            3: return m_mb;
            4: return hw ? m_ca : (m_ca & 255);
            5: return m_ca >> 8;
            6: return hw ? m_cb : (m_cb & 255);
            7: return m_cb >> 8;
            8: return hw ? m_cnt : (m_cnt & 255);
            9: return m_cnt >> 8;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_b0 = 0; m_run = 0; m_ma = 0; m_mb = 0; m_ca = 0; m_cb = 0;
            m_cnt = 0; m_per = 0; m_st = 0;
            m_ovf = 0; m_ha = 0; m_hb = 0; m_ack = 0; m_err = 0; m_rd = 0;
        end else begin
            automatic int a = int'(bus_addr);
            automatic int wd = int'(bus_wdata);
            automatic bit lg = legal_f(a, bus_we, bus_hw, wd);
            automatic bit wr = bus_req && bus_we && lg;
            automatic bit stb = wr && (a == 1 || (a == 0 && bus_hw));
            m_ack = bus_req;
            m_err = bus_req && !lg;
            m_rd  = (bus_req && !bus_we && lg) ? rd_f(a, bus_hw) : 0;
            if (stb) begin
                m_cnt = 0; m_ovf = 0; m_ha = 0; m_hb = 0;
                if ((wd & 'h80) != 0) begin
                    m_per = m_ca;
                    m_st = (m_ca == 0) ? 2 : 1;
                end else m_st = 0;
            end else if (m_st == 1 && cnt_tick) begin
                automatic int nxt = m_cnt + 1;
                m_ha = (m_ma & 1) && nxt == m_ca;
                m_hb = (m_mb & 1) && nxt == m_cb;
                if (nxt == m_per) begin m_cnt = 0; m_ovf = 1; end
                else begin m_cnt = nxt; m_ovf = 0; end
            end else begin
                m_ovf = 0; m_ha = 0; m_hb = 0;
            end
            if (wr) begin
                case (a)
                    0: if (bus_hw) begin m_b0 = (wd >> 8) & 255; m_run = wd & 255; end
                       else m_b0 = wd & 255;
                    1: m_run = wd & 255;
                    2: m_ma = wd & 255;
                    3: m_mb = wd & 255;
                    4: m_ca = bus_hw ? wd : ((m_ca & 'hFF00) | (wd & 255));
                    5: m_ca = (m_ca & 255) | ((wd & 255) << 8);
                    6: m_cb = bus_hw ? wd : ((m_cb & 'hFF00) | (wd & 255));
                    7: m_cb = (m_cb & 255) | ((wd & 255) << 8);
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp1(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%0h expected=%0h", tag, phase, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            cmp1("R9",  "bus_ack",   bus_ack,   m_ack);
            cmp1("R9",  "bus_err",   bus_err,   m_err);
            cmp1("R10", "bus_rdata", bus_rdata, m_rd);
            cmp1("R3",  "ovf_o",     ovf_o,     m_ovf);
            cmp1("R6",  "match_a_o", match_a_o, m_ha);
            cmp1("R6",  "match_b_o", match_b_o, m_hb);
            if (ovf_o) begin
                if (ovf_last >= 0) ovf_gap = cyc - ovf_last;
                ovf_last = cyc;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
        bus_req = 1'b0;
        case (tick_pat)
            0: cnt_tick = 1'b1;
            1: cnt_tick = (cyc % 3 == 0);
            default: cnt_tick = 1'b0;
        endcase
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, bit hw, int d);
        step();
        bus_req = 1'b1; bus_we = 1'b1; bus_hw = hw;
        bus_addr = 4'(a); bus_wdata = 16'(d);
        step();
    endtask

    task automatic rd(int a, bit hw, int exp, string tag);
        step();
        bus_req = 1'b1; bus_we = 1'b0; bus_hw = hw;
        bus_addr = 4'(a); bus_wdata = '0;
        step();
        @(negedge clk);
        cmp1(tag, $sformatf("read addr %0d", a), bus_rdata, exp);
    endtask

    task automatic rd_err(int a, bit hw, string tag);
        step();
        bus_req = 1'b1; bus_we = 1'b0; bus_hw = hw;
        bus_addr = 4'(a);
        step();
        @(negedge clk);
        cmp1(tag, $sformatf("read err addr %0d", a), bus_err, 1);
    endtask

    initial begin
        tick_pat = 2;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset values
        phase = "R1";
        rd(0, 1, 16'h0000, "R1");
        rd(4, 1, 16'h0000, "R1");
        rd(6, 1, 16'h0000, "R1");
        rd(2, 0, 16'h0000, "R1");
        rd(8, 1, 16'h0000, "R1");
        cmp1("R1", "ovf_o idle", ovf_o, 0);

        // R2/R3/R6: period 5, match B at 3
        phase = "R2";
        wr(4, 1, 5);
        wr(6, 1, 3);
        wr(2, 0, 1);
        wr(3, 0, 1);
        rd(4, 0, 16'h0005, "R10");
        tick_pat = 0;
        wr(1, 0, 'h80);
        idle(23);
        cmp1("R3", "overflow gap", ovf_gap, 5);

        // R11: mode byte 0 alone keeps counting
        phase = "R11";
        wr(0, 0, 'h11);
        idle(12);
        cmp1("R11", "overflow gap after byte0 write", ovf_gap, 5);
        rd(0, 1, 16'h1180, "R10");

        // R7: reserved bits of byte 0
        phase = "R7";
        wr(0, 0, 'h04);
        rd(0, 0, 16'h0011, "R7");
        wr(0, 0, 'h20);
        rd(0, 0, 16'h0011, "R7");

        // R8: run-control byte checks
        phase = "R8";
        wr(1, 0, 'hC0);
        rd(1, 0, 16'h0080, "R8");
        wr(1, 0, 'h81);
        rd(1, 0, 16'h0080, "R8");

        // R5: compare A change does not alter running period
        phase = "R5";
        wr(4, 1, 9);
        idle(12);
        cmp1("R5", "period kept at 5", ovf_gap, 5);
        wr(1, 0, 'h80);
        idle(30);
        cmp1("R2", "period relatched to 9", ovf_gap, 9);

        // R2: sparse ticks
        phase = "R2";
        tick_pat = 1;
        idle(60);
        cmp1("R2", "period 9 with tick every 3rd cycle", ovf_gap, 27);
        tick_pat = 0;

        // R5: stop
        phase = "R5";
        wr(1, 0, 'h00);
        idle(15);
        rd(8, 1, 16'h0000, "R5");

        // R4: zero period
        phase = "R4";
        wr(4, 1, 0);
        wr(1, 0, 'h80);
        idle(10);
        rd(8, 1, 16'h0000, "R4");

        // R9: size and address errors
        phase = "R9";
        rd_err(1, 1, "R9");
        rd_err(2, 1, "R9");
        rd_err(5, 1, "R9");
        rd_err(12, 0, "R9");
        rd_err(9, 1, "R9");
        wr(8, 0, 'h12);
        wr(3, 1, 'h0001);
        rd(3, 0, 16'h0001, "R9");
        wr(0, 1, 'h0480);
        rd(0, 1, 16'h1180, "R9");

        // R3 boundary: period 1 via halfword mode write, load bit alone
        phase = "R3";
        wr(4, 0, 1);
        wr(5, 0, 0);
        wr(6, 1, 1);
        wr(0, 1, 'h0180);
        idle(10);
        cmp1("R3", "period 1 gap", ovf_gap, 1);
        rd(0, 1, 16'h0180, "R10");
        wr(1, 0, 'h40);
        idle(5);
        rd(1, 0, 16'h0040, "R8");
        rd(8, 0, 16'h0000, "R5");

        // byte lanes of compare B
        phase = "R10";
        wr(6, 1, 'hA55A);
        rd(7, 0, 16'h00A5, "R10");
        rd(6, 0, 16'h005A, "R10");
        wr(7, 0, 'h3C);
        rd(6, 1, 16'h3C5A, "R10");

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule